// File: doc/BRIEF.md
# Power-Management Event Timer with System Control Interrupt

This block gathers power-management events and turns them into one level-sensitive system control interrupt (SCI). It contains a free-running timer, a status register and an enable register. The timer is 24 bits wide by default and advances by one on every cycle in which the tick strobe is high. The tick is produced outside the block, usually at about 3.58 MHz. Each time the timer's most significant bit changes, in either direction, the overflow status flag is set. The flag therefore fires once every half period of the timer.

Single-cycle pulses from three sources set their own status flags: the real-time clock alarm, the power button and the global-release source. Software reads the registers through a plain register port and clears status flags by writing ones to them. Software chooses which flags can raise the SCI by writing the enable register. The SCI stays high while any enabled flag remains set.

Top module: `pm_event_timer`

## Requirements
- R1: After a synchronous reset the timer, the status register, the enable register and `sci` are all zero.
- R2: The timer increases by one on each cycle with `tick` high, holds otherwise, and wraps modulo 2^TMR_W. A read at offset 0x08 returns the count zero-extended to 32 bits.
- R3: The overflow flag (status bit 0) is set on a tick where the timer's top bit changes value. This happens both on the 0-to-1 and on the 1-to-0 change.
- R4: Once set, the overflow flag stays set through further ticks until software clears it.
- R5: A pulse on `rtc_evt` sets status bit 10, a pulse on `pwrbtn_evt` sets status bit 8, and a pulse on `gbl_evt` sets status bit 5. All other status bits read as zero.
- R6: A write at offset 0x00 clears every status bit written as 1 and leaves the bits written as 0 unchanged. When a set and a clear hit the same bit in one cycle, the bit ends up set.
- R7: A write at offset 0x02 replaces all 16 bits of the enable register, and a read at 0x02 returns them.
- R8: `sci` is high exactly when at least one of bits 0, 5, 8 and 10 is set in both the status and the enable register.
- R9: Only the low 6 bits of `reg_addr` take part in decoding, so 0x42 and 0x82 select the same register as 0x02.
- R10: Writes to offset 0x08 or to any unmapped offset change nothing. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer advance strobe |
| rtc_evt | input | 1 | Real-time clock alarm pulse |
| pwrbtn_evt | input | 1 | Power button pulse |
| gbl_evt | input | 1 | Global-release pulse |
| reg_addr | input | ADDR_W (8) | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sci | output | 1 | System control interrupt, level |

## Verification
The bench builds the block with TMR_W = 10 and leaves the address and window widths at their defaults. With that timer width a half period is only 512 ticks. Both directions of the top-bit change and several full wraps therefore fit into a few thousand cycles of random and directed stimulus. The same width lets the bench watch the overflow flag stay set across later transitions. Random upper address bits exercise the window masking on every access.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;
   localparam int REG_W    = 16;
   localparam int NUM_EXT  = 3;
   localparam int BIT_OVF  = 0;
   localparam int BIT_GBL  = 5;
   localparam int BIT_PWR  = 8;
   localparam int BIT_RTC  = 10;
   localparam logic [REG_W-1:0] SRC_MASK =
      REG_W'((1 << BIT_OVF) | (1 << BIT_GBL) | (1 << BIT_PWR) | (1 << BIT_RTC));
   localparam logic [5:0] OFS_STS = 6'h00;
   localparam logic [5:0] OFS_EN  = 6'h02;
   localparam logic [5:0] OFS_TMR = 6'h08;

   // slot of each external source inside the event vector
   function automatic int ext_slot(input int bitpos);
      case (bitpos)
         BIT_RTC: return 0;
         BIT_PWR: return 1;
         default: return 2;
      endcase
   endfunction
endpackage

// File: rtl/pm_event_tmr.sv
module pm_event_tmr #(
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   output logic [TMR_W-1:0] count,
   output logic             msb_flip
);
   localparam int MSB = TMR_W - 1;

   logic [TMR_W-1:0] count_q;
   logic [TMR_W-1:0] count_nx;

   assign count_nx = count_q + 1'b1;
   assign msb_flip = tick & (count_nx[MSB] ^ count_q[MSB]);
   assign count    = count_q;

   always_ff @(posedge clk) begin
      if (rst)
         count_q <= '0;
      else if (tick)
         count_q <= count_nx;
   end
endmodule

// File: rtl/pm_event_sts.sv
module pm_event_sts
   import pm_event_pkg::*;
#(
   parameter int W    = REG_W,
   parameter int NEXT = NUM_EXT
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NEXT-1:0] ext_set,
   input  logic            ovf_set,
   input  logic            clr_we,
   input  logic [W-1:0]    clr_bits,
   output logic [W-1:0]    sts
);
   for (genvar gb = 0; gb < W; gb++) begin : g_bit
      if (SRC_MASK[gb]) begin : g_live
         logic set_b;
         logic q;
         if (gb == BIT_OVF) begin : g_ovf
            assign set_b = ovf_set;
         end else begin : g_ext
            assign set_b = ext_set[ext_slot(gb)];
         end
         always_ff @(posedge clk) begin
            if (rst)
               q <= 1'b0;
            else if (set_b)
               q <= 1'b1;
            else if (clr_we && clr_bits[gb])
               q <= 1'b0;
         end
         assign sts[gb] = q;
      end else begin : g_dead
         assign sts[gb] = 1'b0;
      end
   end
endmodule

// File: rtl/pm_event_regif.sv
module pm_event_regif
   import pm_event_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int WIN_W  = 6,
   parameter int TMR_W  = 24,
   parameter int RD_W   = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   input  logic [REG_W-1:0]  sts,
   input  logic [TMR_W-1:0]  count,
   output logic [REG_W-1:0]  en,
   output logic              clr_we,
   output logic [REG_W-1:0]  clr_bits,
   output logic [RD_W-1:0]   rdata
);
   logic [WIN_W-1:0] ofs;
   logic [REG_W-1:0] en_q;
   logic [RD_W-1:0]  count_ext;

   assign ofs = addr[WIN_W-1:0];

   if (TMR_W == RD_W) begin : g_full
      assign count_ext = count;
   end else begin : g_pad
      assign count_ext = {{(RD_W-TMR_W){1'b0}}, count};
   end

   always_ff @(posedge clk) begin
      if (rst)
         en_q <= '0;
      else if (wr && ofs == WIN_W'(OFS_EN))
         en_q <= wdata;
   end

   assign en       = en_q;
   assign clr_we   = wr && (ofs == WIN_W'(OFS_STS));
   assign clr_bits = wdata;

   always_comb begin
      rdata = '0;
      if (ofs == WIN_W'(OFS_STS))
         rdata = RD_W'(sts);
      else if (ofs == WIN_W'(OFS_EN))
         rdata = RD_W'(en_q);
      else if (ofs == WIN_W'(OFS_TMR))
         rdata = count_ext;
   end
endmodule

// File: rtl/pm_event_timer.sv
module pm_event_timer
   import pm_event_pkg::*;
#(
   parameter int TMR_W  = 24,
   parameter int ADDR_W = 8,
   parameter int WIN_W  = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              rtc_evt,
   input  logic              pwrbtn_evt,
   input  logic              gbl_evt,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [15:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              sci
);
   localparam int RD_W = 32;

   if (TMR_W < 2 || TMR_W > RD_W) begin : g_bad_tmr
      $error("pm_event_timer: TMR_W must lie in 2..32");
   end
   if (WIN_W < 4 || WIN_W > ADDR_W) begin : g_bad_win
      $error("pm_event_timer: WIN_W must lie in 4..ADDR_W");
   end

   logic [TMR_W-1:0]   tmr_cnt;
   logic               tmr_flip;
   logic [REG_W-1:0]   sts_q;
   logic [REG_W-1:0]   en_q;
   logic               clr_we;
   logic [REG_W-1:0]   clr_bits;
   logic [NUM_EXT-1:0] ext_set;

   assign ext_set = {gbl_evt, pwrbtn_evt, rtc_evt};

   pm_event_tmr #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst(rst), .tick(tick),
      .count(tmr_cnt), .msb_flip(tmr_flip)
   );

   pm_event_sts #(.W(REG_W), .NEXT(NUM_EXT)) u_sts (
      .clk(clk), .rst(rst), .ext_set(ext_set), .ovf_set(tmr_flip),
      .clr_we(clr_we), .clr_bits(clr_bits), .sts(sts_q)
   );

   pm_event_regif #(
      .ADDR_W(ADDR_W), .WIN_W(WIN_W), .TMR_W(TMR_W), .RD_W(RD_W)
   ) u_regif (
      .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr),
      .wdata(reg_wdata), .sts(sts_q), .count(tmr_cnt),
      .en(en_q), .clr_we(clr_we), .clr_bits(clr_bits), .rdata(reg_rdata)
   );

   assign sci = |(sts_q & en_q & SRC_MASK);
endmodule

// File: rtl/pm_event_timer_chk.sv
module pm_event_timer_chk
   import pm_event_pkg::*;
#(
   parameter int TMR_W  = 24,
   parameter int ADDR_W = 8,
   parameter int WIN_W  = 6
) (
   input logic              clk,
   input logic              rst,
   input logic              tick,
   input logic              rtc_evt,
   input logic              pwrbtn_evt,
   input logic              gbl_evt,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [15:0]       reg_wdata,
   input logic [TMR_W-1:0]  cnt,
   input logic [REG_W-1:0]  sts,
   input logic [REG_W-1:0]  en,
   input logic              sci
);
   logic [WIN_W-1:0] ofs;
   assign ofs = reg_addr[WIN_W-1:0];

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (cnt == '0 && sts == '0 && en == '0 && !sci));

   // R2
   tick_step_chk: assert property (@(posedge clk) disable iff (rst)
      tick |=> cnt == TMR_W'($past(cnt) + 1'b1));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt));

   // R3
   half_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && &cnt[TMR_W-2:0]) |=> sts[BIT_OVF]);

   // R4
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (sts[BIT_OVF] && !(reg_wr && ofs == WIN_W'(OFS_STS) && reg_wdata[BIT_OVF]))
      |=> sts[BIT_OVF]);

   // R5
   rtc_set_chk: assert property (@(posedge clk) disable iff (rst)
      rtc_evt |=> sts[BIT_RTC]);

   // R5
   pwr_set_chk: assert property (@(posedge clk) disable iff (rst)
      pwrbtn_evt |=> sts[BIT_PWR]);

   // R5
   gbl_set_chk: assert property (@(posedge clk) disable iff (rst)
      gbl_evt |=> sts[BIT_GBL]);

   // R6
   w1c_rtc_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && ofs == WIN_W'(OFS_STS) && reg_wdata[BIT_RTC] && !rtc_evt)
      |=> !sts[BIT_RTC]);

   // R7 R9
   en_write_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && ofs == WIN_W'(OFS_EN)) |=> en == $past(reg_wdata));

   // R8
   sci_raise_chk: assert property (@(posedge clk) disable iff (rst)
      (rtc_evt && en[BIT_RTC] && !(reg_wr && ofs == WIN_W'(OFS_EN))) |=> sci);

   // R10
   en_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !(reg_wr && ofs == WIN_W'(OFS_EN)) |=> $stable(en));
endmodule

bind pm_event_timer pm_event_timer_chk #(
   .TMR_W(TMR_W), .ADDR_W(ADDR_W), .WIN_W(WIN_W)
) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .rtc_evt(rtc_evt),
   .pwrbtn_evt(pwrbtn_evt), .gbl_evt(gbl_evt), .reg_addr(reg_addr),
   .reg_wr(reg_wr), .reg_wdata(reg_wdata), .cnt(tmr_cnt),
   .sts(sts_q), .en(en_q), .sci(sci)
);

// File: tb/tb_pm_event_timer.sv
module tb_pm_event_timer;
   localparam int TW = 10;
   localparam logic [15:0] MASK = 16'h0521;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick = 1'b0;
   logic        rtc_evt = 1'b0;
   logic        pwrbtn_evt = 1'b0;
   logic        gbl_evt = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sci;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [TW-1:0] m_cnt = '0;
   logic [15:0]   m_sts = '0;
   logic [15:0]   m_en  = '0;

   pm_event_timer #(.TMR_W(TW)) dut (
      .clk(clk), .rst(rst), .tick(tick), .rtc_evt(rtc_evt),
      .pwrbtn_evt(pwrbtn_evt), .gbl_evt(gbl_evt), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sci(sci)
   );

   always #5 clk = ~clk;

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      case (a[5:0])
         6'h00:   return {16'h0, m_sts};
         6'h02:   return {16'h0, m_en};
         6'h08:   return {{(32-TW){1'b0}}, m_cnt};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string lbl(input logic [7:0] a);
      case (a[5:0])
         6'h00:   return "R6";
         6'h02:   return "R7";
         6'h08:   return "R2";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive, check current state, advance the model
   task automatic cyc(input bit r, input bit t, input bit er, input bit ep,
                      input bit eg, input bit w, input logic [7:0] a,
                      input logic [15:0] d, input string req);
      logic [TW-1:0] nxt;
      logic [15:0]   clr;
      logic [15:0]   set;
      @(negedge clk);
      rst = r; tick = t; rtc_evt = er; pwrbtn_evt = ep; gbl_evt = eg;
      reg_wr = w; reg_addr = a; reg_wdata = d;
      #1;
      chk(reg_rdata, exp_rd(a), req);
      chk({31'h0, sci}, {31'h0, |(m_sts & m_en & MASK)}, "R8");
      if (r) begin
         m_cnt = '0; m_sts = '0; m_en = '0;
      end else begin
         nxt = m_cnt + 1'b1;
         clr = (w && a[5:0] == 6'h00) ? d : 16'h0;
         set = '0;
         set[0]  = t && (nxt[TW-1] != m_cnt[TW-1]);
         set[10] = er;
         set[8]  = ep;
         set[5]  = eg;
         m_sts = ((m_sts & ~clr) | set) & MASK;
         if (w && a[5:0] == 6'h02) m_en = d;
         if (t) m_cnt = nxt;
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1d4c_07a5));
      // R1: reset state visible on every register
      cyc(1, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R1");
      cyc(1, 1, 1, 1, 1, 0, 8'h02, 16'h0, "R1");
      cyc(0, 0, 0, 0, 0, 0, 8'h08, 16'h0, "R1");
      cyc(0, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R1");
      // R9: aliased window writes and reads
      cyc(0, 0, 0, 0, 0, 1, 8'h42, 16'hFFFF, "R9");
      cyc(0, 0, 0, 0, 0, 0, 8'h82, 16'h0, "R9");
      cyc(0, 0, 0, 0, 0, 1, 8'hC2, 16'h0521, "R9");
      cyc(0, 0, 0, 0, 0, 0, 8'h02, 16'h0, "R7");
      // R10: timer and unmapped offsets ignore writes
      cyc(0, 0, 0, 0, 0, 1, 8'h08, 16'hFFFF, "R10");
      cyc(0, 0, 0, 0, 0, 1, 8'h0C, 16'hFFFF, "R10");
      cyc(0, 0, 0, 0, 0, 0, 8'h08, 16'h0, "R10");
      cyc(0, 0, 0, 0, 0, 0, 8'h0C, 16'h0, "R10");
      cyc(0, 0, 0, 0, 0, 0, 8'h02, 16'h0, "R10");
      // R3: rising top bit after half a period
      for (int i = 0; i < (1 << (TW-1)); i++)
         cyc(0, 1, 0, 0, 0, 0, 8'h08, 16'h0, "R2");
      cyc(0, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R3");
      chk(reg_rdata & 32'h1, 32'h1, "R3");
      // R4: stays set while more ticks arrive
      for (int i = 0; i < 100; i++)
         cyc(0, 1, 0, 0, 0, 0, 8'h00, 16'h0, "R4");
      cyc(0, 0, 0, 0, 0, 1, 8'h00, 16'h0001, "R6");
      cyc(0, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R6");
      chk(reg_rdata & 32'h1, 32'h0, "R6");
      // R3: falling top bit at the wrap
      for (int i = 0; i < (1 << (TW-1)) - 100; i++)
         cyc(0, 1, 0, 0, 0, 0, 8'h00, 16'h0, "R3");
      cyc(0, 0, 0, 0, 0, 0, 8'h08, 16'h0, "R2");
      chk(reg_rdata, 32'h0, "R2");
      cyc(0, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R3");
      chk(reg_rdata & 32'h1, 32'h1, "R3");
      cyc(0, 0, 0, 0, 0, 1, 8'h00, 16'hFFFF, "R6");
      // R6: set beats a same-cycle clear; R5: each source
      cyc(0, 0, 1, 0, 0, 1, 8'h00, 16'h0400, "R6");
      cyc(0, 0, 0, 1, 1, 0, 8'h00, 16'h0, "R6");
      chk(reg_rdata, 32'h0400, "R6");
      cyc(0, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R5");
      chk(reg_rdata, 32'h0520, "R5");
      cyc(0, 0, 0, 0, 0, 1, 8'h00, 16'h0100, "R6");
      cyc(0, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R6");
      chk(reg_rdata, 32'h0420, "R6");
      // R8: masking drops the interrupt
      cyc(0, 0, 0, 0, 0, 1, 8'h02, 16'hFADE, "R7");
      cyc(0, 0, 0, 0, 0, 0, 8'h02, 16'h0, "R8");
      chk({31'h0, sci}, 32'h0, "R8");
      // constrained random mix
      for (int i = 0; i < 6000; i++) begin
         logic [7:0]  a;
         logic [5:0]  o;
         logic [15:0] d;
         bit          w;
         case ($urandom_range(0, 5))
            0: o = 6'h00;
            1: o = 6'h02;
            2: o = 6'h08;
            3: o = 6'h04;
            4: o = 6'h06;
            default: o = 6'($urandom);
         endcase
         a = {2'($urandom), o};
         w = ($urandom_range(0, 7) == 0);
         d = 16'($urandom);
         if (o == 6'h00 && $urandom_range(0, 1) == 0) d = d & 16'h00FF;
         cyc(0, $urandom_range(0, 3) != 0, $urandom_range(0, 40) == 0,
             $urandom_range(0, 40) == 0, $urandom_range(0, 40) == 0,
             w, a, d, lbl(a));
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule